// File: doc/BRIEF.md
# Memory Array Integrity Signature Engine

This block runs a built-in integrity check over a memory array. Software picks which address blocks count toward the result, loads a starting value into the signature segments, chooses how the walk orders its addresses and then sets the enable bit. The engine reads every word of the array through a synchronous read port, one read per cycle. It folds each word that comes from a selected block into a multiple-input signature register (MISR), and it raises a done flag after the last read has come back.

The walk always covers the whole array, so an ECC error in any block is recorded in a sticky status bit, even when that block is not folded. Sequential ordering gives the shortest check. The alternating ordering pairs every address with its bitwise complement, so that every address line toggles on the second read of each pair, and it takes twice as many reads. Software compares the signature with a stored reference and then clears the enable bit. If it clears the enable bit before done, the walk stops and the signature keeps the partial value it had reached. While the engine is busy, the surrounding logic must hold off normal reads of the array.

Top module: `mse_engine`

## Requirements
- R1: A register write to address 0 with bit 0 at 1, made while the enable bit is 0, starts a walk. From the next cycle `busy` is high, `mem_rd_en` is high and the first address issued is 0.
- R2: With bit 1 of that start write at 1 (sequential order), the engine reads addresses 0 to DEPTH-1 in rising order, one per cycle. `done` is first high DEPTH+1 clock edges after the start write.
- R3: With bit 1 at 0 (alternating order), for each i from 0 to DEPTH-1 the engine reads i and then its bitwise complement, 2*DEPTH reads in all. `done` is first high 2*DEPTH+1 edges after the start write.
- R4: Each returned word whose address has its top BLK_W bits naming a block with a 1 in the select register (address 1) updates the signature as sig = rotate-left-by-1(sig) XOR (TAPS if the old MSB was 1) XOR zero-extended word. Signature segment k is read and written at register address 2+k and holds bits [8k+7:8k].
- R5: Words from blocks whose select bit is 0 are read but leave the signature unchanged. With an all-zero select register the signature still equals the seed after done.
- R6: Status register (address 7) bit 1 becomes 1 if any read of the walk returns an ECC error, whether or not its block is selected. It stays 1 when the enable bit is cleared and returns to 0 only at the next start.
- R7: Writing 0 to the enable bit before done stops the walk. From the next cycle `mem_rd_en` and `busy` are 0, `done` stays 0 and the signature no longer changes.
- R8: Writing 0 to the enable bit clears `done` (status bit 0). Writing the enable bit as 1 while it is already 1 does not start a new walk.
- R9: While `busy` is high, writes to the signature segments and to the select register are ignored. While idle, they load the written value.
- R10: `busy` (also status bit 2) is high from the first read issued until the last read has returned, and `done` is never high while `busy` is high. `busy` tells the surrounding logic to hold off normal reads.
- R11: After reset the enable bit, `done`, `busy`, the status bits, the select register and all signature segments are 0, and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 block select, 2..6 signature segments, 7 status |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_addr |
| mem_rd_en | output | 1 | Array read request; the data returns on the next cycle |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | REG_W | Array read data, one cycle after the request |
| mem_ecc_err | input | 1 | ECC error flag that comes with mem_rdata |
| busy | output | 1 | Walk in progress; normal array reads must be held off |
| done | output | 1 | Walk completed |

## Verification
A wrong step in the address sequencer appears on `mem_addr` in the same cycle, so the bench logs every issued address and compares the order and the count with the selected mode. It also checks the exact edge on which `done` rises. A fault in the fold path or in block decoding only becomes visible when the signature is read back after done. The bench therefore runs several seeds, select masks and orderings through the reference fold, including an all-zero mask where the result must equal the seed. Errors in abort, sticky-ECC or write-gating state appear at the ports one cycle after the write that triggers them, and the bench reads status and segments directly after each such write.

// File: rtl/mse_pkg.sv
package mse_pkg;
   localparam int unsigned RA_W = 3;
   localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
   localparam logic [RA_W-1:0] RA_SEL  = 3'd1;
   localparam logic [RA_W-1:0] RA_SIG0 = 3'd2;
   localparam logic [RA_W-1:0] RA_STAT = 3'd7;
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_SEQ  = 1;
   localparam int unsigned SB_DONE = 0;
   localparam int unsigned SB_ECC  = 1;
   localparam int unsigned SB_BUSY = 2;
endpackage

// File: rtl/mse_addr_seq.sv
module mse_addr_seq #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              seq_i,
   input  logic              stop_i,
   output logic              issue_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o,
   output logic              phase_o,
   output logic              seq_mode_o
);
   localparam logic [ADDR_W-1:0] IDX_MAX = {ADDR_W{1'b1}};

   logic              active_q, seq_q, phase_q;
   logic [ADDR_W-1:0] idx_q;

   assign last_o     = active_q && (idx_q == IDX_MAX) && (seq_q || phase_q);
   assign addr_o     = (!seq_q && phase_q) ? ~idx_q : idx_q;
   assign issue_o    = active_q;
   assign phase_o    = phase_q;
   assign seq_mode_o = seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         seq_q    <= 1'b0;
         phase_q  <= 1'b0;
         idx_q    <= '0;
      end else if (stop_i) begin
         active_q <= 1'b0;
      end else if (start_i) begin
         active_q <= 1'b1;
         seq_q    <= seq_i;
         phase_q  <= 1'b0;
         idx_q    <= '0;
      end else if (active_q) begin
         if (last_o) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
         end else if (seq_q) begin
            idx_q <= idx_q + 1'b1;
         end else if (phase_q) begin
            phase_q <= 1'b0;
            idx_q   <= idx_q + 1'b1;
         end else begin
            phase_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mse_misr.sv
module mse_misr #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned SIG_SEGS = 5,
   parameter logic [63:0] TAPS     = 64'h31
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              fold_i,
   input  logic [REG_W-1:0]                  data_i,
   input  logic                              seed_we_i,
   input  logic [2:0]                        seed_idx_i,
   input  logic [REG_W-1:0]                  seed_i,
   output logic [REG_W*SIG_SEGS-1:0]         sig_o
);
   localparam int unsigned SIG_W = REG_W * SIG_SEGS;

   logic [SIG_W-1:0] sig_q, folded, sig_d;

   assign folded = {sig_q[SIG_W-2:0], sig_q[SIG_W-1]}
                 ^ (sig_q[SIG_W-1] ? TAPS[SIG_W-1:0] : {SIG_W{1'b0}})
                 ^ {{(SIG_W-REG_W){1'b0}}, data_i};

   for (genvar k = 0; k < SIG_SEGS; k++) begin : g_seg
      always_comb begin
         if (fold_i)
            sig_d[k*REG_W +: REG_W] = folded[k*REG_W +: REG_W];
         else if (seed_we_i && seed_idx_i == 3'(k))
            sig_d[k*REG_W +: REG_W] = seed_i;
         else
            sig_d[k*REG_W +: REG_W] = sig_q[k*REG_W +: REG_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= '0;
      else        sig_q <= sig_d;
   end

   assign sig_o = sig_q;
endmodule

// File: rtl/mse_engine.sv
module mse_engine
   import mse_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned BLK_W    = 2,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned SIG_SEGS = 5,
   parameter logic [63:0] TAPS     = 64'h31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [REG_W-1:0]  mem_rdata,
   input  logic              mem_ecc_err,
   output logic              busy,
   output logic              done
);
   localparam int unsigned NUM_BLK = 1 << BLK_W;
   localparam int unsigned SIG_W   = REG_W * SIG_SEGS;

   if (BLK_W < 1 || BLK_W > ADDR_W || NUM_BLK > REG_W) begin : g_bad_blk
      $error("mse_engine: block count does not fit address or register width");
   end
   if (SIG_SEGS < 2 || SIG_SEGS > 5) begin : g_bad_segs
      $error("mse_engine: signature segment count must be 2..5");
   end
   if (REG_W < 3 || SIG_W > 64) begin : g_bad_width
      $error("mse_engine: register or signature width out of range");
   end

   logic               en_q, done_q, ecc_q;
   logic [NUM_BLK-1:0] sel_q;
   logic               rv_q, rsel_q, rlast_q;
   logic               issue_last, alt_phase, run_seq;
   logic [SIG_W-1:0]   sig;

   logic ctrl_wr, start, stop_wr, accept, fold, seed_we, sel_we;
   logic [2:0] seed_idx;

   assign ctrl_wr  = reg_we && (reg_addr == RA_CTRL);
   assign start    = ctrl_wr && reg_wdata[CB_EN] && !en_q;
   assign stop_wr  = ctrl_wr && !reg_wdata[CB_EN];
   assign accept   = rv_q && !stop_wr;
   assign fold     = accept && rsel_q;
   assign seed_idx = reg_addr - RA_SIG0;
   assign seed_we  = reg_we && !busy && (reg_addr >= RA_SIG0)
                     && (seed_idx < 3'(SIG_SEGS));
   assign sel_we   = reg_we && !busy && (reg_addr == RA_SEL);
   assign busy     = mem_rd_en || rv_q;
   assign done     = done_q;

   mse_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .seq_i     (reg_wdata[CB_SEQ]),
      .stop_i    (stop_wr),
      .issue_o   (mem_rd_en),
      .addr_o    (mem_addr),
      .last_o    (issue_last),
      .phase_o   (alt_phase),
      .seq_mode_o(run_seq)
   );

   mse_misr #(.REG_W(REG_W), .SIG_SEGS(SIG_SEGS), .TAPS(TAPS)) u_misr (
      .clk       (clk),
      .rst_n     (rst_n),
      .fold_i    (fold),
      .data_i    (mem_rdata),
      .seed_we_i (seed_we),
      .seed_idx_i(seed_idx),
      .seed_i    (reg_wdata),
      .sig_o     (sig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         done_q  <= 1'b0;
         ecc_q   <= 1'b0;
         sel_q   <= '0;
         rv_q    <= 1'b0;
         rsel_q  <= 1'b0;
         rlast_q <= 1'b0;
      end else begin
         if (ctrl_wr) en_q <= reg_wdata[CB_EN];
         if (sel_we)  sel_q <= reg_wdata[NUM_BLK-1:0];
         rv_q    <= mem_rd_en && !stop_wr;
         rsel_q  <= sel_q[mem_addr[ADDR_W-1 -: BLK_W]];
         rlast_q <= issue_last;
         if (start || stop_wr)       done_q <= 1'b0;
         else if (accept && rlast_q) done_q <= 1'b1;
         if (start)                         ecc_q <= 1'b0;
         else if (accept && mem_ecc_err)    ecc_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RA_CTRL) begin
         reg_rdata[CB_EN]  = en_q;
         reg_rdata[CB_SEQ] = run_seq;
      end else if (reg_addr == RA_SEL) begin
         reg_rdata[NUM_BLK-1:0] = sel_q;
      end else if (reg_addr == RA_STAT) begin
         reg_rdata[SB_DONE] = done_q;
         reg_rdata[SB_ECC]  = ecc_q;
         reg_rdata[SB_BUSY] = busy;
      end else begin
         for (int k = 0; k < int'(SIG_SEGS); k++)
            if (seed_idx == 3'(k)) reg_rdata = sig[k*REG_W +: REG_W];
      end
   end
endmodule

// File: rtl/mse_checker.sv
module mse_checker #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned SIG_W  = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy,
   input logic              done,
   input logic              run_seq,
   input logic              alt_phase,
   input logic              ecc_flag,
   input logic              start,
   input logic              stop_wr,
   input logic              rv,
   input logic              seed_we,
   input logic [SIG_W-1:0]  sig
);
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en) && run_seq) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2
   AST_ALT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en) && !run_seq && alt_phase) |-> (mem_addr == ~$past(mem_addr))); // R3
   AST_DONE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(rv)); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_ECC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ecc_flag) && !$past(start)) |-> ecc_flag); // R6
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_wr) |-> (!mem_rd_en && !done)); // R7
   AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rv) && !$past(seed_we)) |-> $stable(sig)); // R5
endmodule

bind mse_engine mse_checker #(.ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd_en(mem_rd_en),
   .mem_addr (mem_addr),
   .busy     (busy),
   .done     (done),
   .run_seq  (run_seq),
   .alt_phase(alt_phase),
   .ecc_flag (ecc_q),
   .start    (start),
   .stop_wr  (stop_wr),
   .rv       (rv_q),
   .seed_we  (seed_we),
   .sig      (sig)
);

// File: tb/mse_engine_bench.sv
module mse_engine_bench;
   import mse_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 64;
   localparam logic [39:0] TAPS_REF = 40'h31;

   // vector: {seq_mode, sel[3:0], seed[7:0], ecc_on, ecc_addr[5:0]}
   localparam logic [19:0] VEC [6] = '{
      {1'b1, 4'hF, 8'h00, 1'b0, 6'h00},
      {1'b1, 4'h5, 8'h3C, 1'b1, 6'h10},
      {1'b0, 4'hF, 8'hA5, 1'b0, 6'h00},
      {1'b0, 4'h2, 8'h11, 1'b1, 6'h35},
      {1'b1, 4'h8, 8'hFF, 1'b1, 6'h3F},
      {1'b0, 4'h0, 8'h7E, 1'b0, 6'h00}
   };

   logic       clk, rst_n, reg_we, mem_rd_en, mem_ecc_err, busy, done;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata, mem_rdata;
   logic [5:0] mem_addr;

   int n_chk = 0, n_bad = 0;
   logic       ecc_on = 1'b0, log_clr = 1'b0;
   logic [5:0] ecc_at = '0;
   logic [5:0] log_a [256];
   int         log_n = 0;

   mse_engine u_mse_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ecc_err(mem_ecc_err),
      .busy(busy), .done(done)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] memval(input logic [5:0] a);
      return (({2'b00, a} * 8'd29) + 8'd7) ^ {2'b00, a};
   endfunction

   function automatic logic [5:0] expaddr(input logic m, input int j);
      if (m) return 6'(j);
      return (j % 2 == 1) ? ~6'(j / 2) : 6'(j / 2);
   endfunction

   function automatic logic [39:0] model(input logic m, input logic [3:0] sel,
                                         input logic [39:0] seed);
      logic [39:0] s;
      s = seed;
      for (int j = 0; j < (m ? DEPTH : 2*DEPTH); j++) begin
         logic [5:0] a;
         a = expaddr(m, j);
         if (sel[a[5:4]])
            s = {s[38:0], s[39]} ^ (s[39] ? TAPS_REF : 40'h0) ^ {32'h0, memval(a)};
      end
      return s;
   endfunction

   always @(posedge clk) begin
      if (log_clr) log_n <= 0;
      else if (mem_rd_en) begin
         if (log_n < 256) log_a[log_n] <= mem_addr;
         log_n <= log_n + 1;
      end
      mem_rdata   <= memval(mem_addr);
      mem_ecc_err <= mem_rd_en && ecc_on && (mem_addr == ecc_at);
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rdsig(output logic [39:0] s);
      for (int k = 0; k < 5; k++) begin
         logic [7:0] d;
         rdreg(RA_SIG0 + 3'(k), d);
         s[k*8 +: 8] = d;
      end
   endtask

   task automatic clr_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   task automatic run(input logic m, output int cyc);
      wr(RA_CTRL, {6'b0, m, 1'b1});
      cyc = 0;
      while (!done && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0]  d;
      logic [39:0] s, s2, seedv;
      int          cyc, nb, seen;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rdreg(RA_STAT, d); chk("R11 status", d, 8'h00);
      rdreg(RA_CTRL, d); chk("R11 ctrl", d, 8'h00);
      rdreg(RA_SEL, d);  chk("R11 select", d, 8'h00);
      rdsig(s);          chk("R11 signature", s, 40'h0);
      chk("R11 rd_en", mem_rd_en, 1'b0);

      // vector table walk
      for (int v = 0; v < 6; v++) begin
         logic m, e; logic [3:0] sel; logic [7:0] sd; logic [5:0] ea;
         {m, sel, sd, e, ea} = VEC[v];
         wr(RA_SEL, {4'b0, sel});
         for (int k = 0; k < 5; k++) begin
            seedv[k*8 +: 8] = sd + 8'(k * 8'h13);
            wr(RA_SIG0 + 3'(k), sd + 8'(k * 8'h13));
         end
         ecc_on = e; ecc_at = ea;
         clr_log();
         run(m, cyc);
         if (m) chk("R2 done cycle", cyc, DEPTH + 1);
         else   chk("R3 done cycle", cyc, 2*DEPTH + 1);
         nb = 0;
         for (int j = 0; j < (m ? DEPTH : 2*DEPTH); j++)
            if (log_a[j] !== expaddr(m, j)) nb++;
         if (m) chk("R2 read order", {log_n, nb}, {m ? DEPTH : 2*DEPTH, 0});
         else   chk("R3 read order", {log_n, nb}, {2*DEPTH, 0});
         rdsig(s);
         chk(sel == 4'h0 ? "R5 seed kept" : "R4 signature", s, model(m, sel, seedv));
         rdreg(RA_STAT, d);
         chk("R6 ecc flag", d[SB_ECC], e);
         chk("R10 idle at done", {busy, d[SB_BUSY]}, 2'b00);
         wr(RA_CTRL, 8'h00);
         rdreg(RA_STAT, d);
         chk("R8 done cleared", {done, d[SB_DONE]}, 2'b00);
         chk("R6 ecc kept after clear", d[SB_ECC], e);
      end
      ecc_on = 1'b0;

      // R1 start behaviour and R6 clear at start
      wr(RA_SEL, 8'h0F);
      clr_log();
      wr(RA_CTRL, 8'h03);
      chk("R1 busy after start", {busy, mem_rd_en, mem_addr}, {1'b1, 1'b1, 6'd0});
      rdreg(RA_STAT, d);
      chk("R6 ecc cleared at start", d[SB_ECC], 1'b0);
      chk("R10 status busy", d[SB_BUSY], 1'b1);
      cyc = 0;
      while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
      // R8: re-enable while enabled does not restart
      seen = log_n;
      wr(RA_CTRL, 8'h03);
      repeat (3) @(negedge clk);
      chk("R8 no restart", {done, busy, 32'(log_n)}, {1'b1, 1'b0, 32'(seen)});
      wr(RA_CTRL, 8'h00);

      // R9 writes ignored while busy; R5 no fold with empty select
      wr(RA_SEL, 8'h00);
      for (int k = 0; k < 5; k++) begin
         seedv[k*8 +: 8] = 8'h40 + 8'(k);
         wr(RA_SIG0 + 3'(k), 8'h40 + 8'(k));
      end
      wr(RA_CTRL, 8'h01);
      repeat (3) @(negedge clk);
      wr(RA_SIG0, 8'hAA);
      wr(RA_SEL, 8'h0F);
      cyc = 0;
      while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
      rdsig(s);
      chk("R9 seed write ignored", s, seedv);
      rdreg(RA_SEL, d);
      chk("R9 select write ignored", d, 8'h00);
      wr(RA_CTRL, 8'h00);
      wr(RA_SIG0, 8'h5A);
      rdreg(RA_SIG0, d);
      chk("R9 seed write when idle", d, 8'h5A);

      // R7 abort
      wr(RA_SEL, 8'h0F);
      clr_log();
      wr(RA_CTRL, 8'h03);
      repeat (10) @(negedge clk);
      wr(RA_CTRL, 8'h00);
      chk("R7 stopped", {mem_rd_en, busy, done}, 3'b000);
      rdsig(s);
      repeat (5) @(negedge clk);
      rdsig(s2);
      chk("R7 signature frozen", s2, s);
      chk("R7 partial walk", (log_n > 0 && log_n < DEPTH), 1'b1);
      rdreg(RA_STAT, d);
      chk("R7 status idle", d[2:0], 3'b000);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule